// File: doc/BRIEF.md
# Invalidate Queue with Early Acknowledge

This block sits beside one core's cache and takes in invalidate messages that other cores send for lines the core may hold. Each message is stored in a small in-order queue and acknowledged in the same cycle it is stored. The requester does not have to wait for the local line-state array to change. Stored invalidates are later applied to that array, oldest first, at most one per cycle. A queued invalidate is applied when the cache reports a free update slot, when a read barrier is draining the queue, or when a fill needs the same line.

Ordinary loads read the line-state array directly and never look into the queue. A load can therefore still see a Shared copy whose invalidate is waiting. This weaker ordering is intended. Software that needs ordering pulses the read-barrier input. The block then raises a stall that holds back loads until every invalidate queued before the barrier has been applied.

A fill that installs a new state into a line is a line-state action, so it must check the queue first. If an invalidate for that line is still pending, the fill waits and the queue is drained until that invalidate has been applied. The block holds a small line-state array so that these effects can be seen at its ports. Line states are encoded as 0 Invalid, 1 Shared, 2 Exclusive and 3 Modified.

Top module: `inval_queue_early_ack`

## Requirements
- R1: When the queue holds fewer than DEPTH entries, a valid invalidate is acknowledged in the same cycle (`inv_ack_o` high) and stored.
- R2: When the queue holds DEPTH entries, `inv_ack_o` stays low and the request is not stored. The requester holds it until a later cycle acknowledges it.
- R3: At most one entry is applied per cycle, in arrival order. `apply_valid_o` and `apply_line_o` show the oldest entry in the cycle it is applied.
- R4: From the cycle after an entry is applied, its line reads as Invalid (state 0), unless a later fill rewrites that line.
- R5: An entry is applied only when at least one holds: `upd_free_i` is high, a barrier stall is active, or a fill to a line that has a pending entry is requested. Otherwise entries stay queued.
- R6: A load that is not stalled is ready in the same cycle and returns the line's current state, even a stale Shared state whose invalidate is still queued.
- R7: A fill whose line matches any queued entry gets `fill_ready_o` low and forces draining. Once no entry matches, the fill is ready and its state is written into the line on that clock edge.
- R8: A `rbar_i` pulse while N>0 entries are queued raises `rbar_stall_o` from the next cycle. The stall stays high until those N entries have been applied and falls in the cycle after the last of them is applied.
- R9: While `rbar_stall_o` is high, `ld_ready_o` is low.
- R10: A `rbar_i` pulse with an empty queue causes no stall. Entries accepted in the same cycle as the pulse are not covered by it.
- R11: After reset the queue is empty, all lines are Invalid, the stall is low and no entry is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| inv_valid_i | input | 1 | Incoming invalidate request |
| inv_line_i | input | LW | Line index of the incoming invalidate |
| inv_ack_o | output | 1 | Invalidate accepted and acknowledged this cycle |
| upd_free_i | input | 1 | Cache line-state port free for a background update |
| apply_valid_o | output | 1 | A queued invalidate is applied this cycle |
| apply_line_o | output | LW | Line being set Invalid |
| fill_req_i | input | 1 | Request to install a line state |
| fill_line_i | input | LW | Line to install |
| fill_state_i | input | 2 | State to install |
| fill_ready_o | output | 1 | Fill accepted this cycle |
| ld_req_i | input | 1 | Load lookup request |
| ld_line_i | input | LW | Line looked up by the load |
| ld_ready_o | output | 1 | Load may read the state this cycle |
| ld_state_o | output | 2 | State of the looked-up line |
| rbar_i | input | 1 | Read-barrier pulse |
| rbar_stall_o | output | 1 | Loads held back by a read barrier |

## Verification
The hardest case to reach is a barrier issued while the queue is full and the background update slot stays closed. In that case only the barrier can drain the queue, and loads aimed at lines whose invalidates are still pending must first return stale Shared, then be blocked, then return Invalid. A directed phase sets this up. It fills lines, queues invalidates with `upd_free_i` held low, reads stale states, and then pulses the barrier. A fill that collides with a pending entry is also aimed at the entry at the back of the queue, so that it forces several applies before it goes through. Random traffic with a fixed seed then mixes all inputs and is compared every cycle against a reference model in the bench.

// File: rtl/iq_pkg.sv
package iq_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_e;
endpackage

// File: rtl/iq_fifo.sv
module iq_fifo #(
    parameter int DEPTH = 4,
    parameter int LW    = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic [LW-1:0] push_line_i,
    input  logic          pop_i,
    input  logic [LW-1:0] probe_line_i,
    output logic [LW-1:0] head_line_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          probe_hit_o
);
    typedef struct packed {
        logic [DEPTH-1:0][LW-1:0] line;
        logic [DEPTH-1:0]         vld;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } fifo_t;

    fifo_t q_q, q_d;
    logic [DEPTH-1:0] hit_vec;

    assign full_o      = (q_q.cnt == CW'(DEPTH));
    assign empty_o     = (q_q.cnt == '0);
    assign count_o     = q_q.cnt;
    assign head_line_o = q_q.line[q_q.rd];

    for (genvar g = 0; g < DEPTH; g++) begin : g_probe
        assign hit_vec[g] = q_q.vld[g] && (q_q.line[g] == probe_line_i);
    end
    assign probe_hit_o = |hit_vec;

    always_comb begin
        q_d = q_q;
        if (pop_i && !empty_o) begin
            q_d.vld[q_q.rd] = 1'b0;
            q_d.rd = (q_q.rd == PW'(DEPTH - 1)) ? '0 : q_q.rd + 1'b1;
        end
        if (push_i && !full_o) begin
            q_d.line[q_q.wr] = push_line_i;
            q_d.vld[q_q.wr]  = 1'b1;
            q_d.wr = (q_q.wr == PW'(DEPTH - 1)) ? '0 : q_q.wr + 1'b1;
        end
        q_d.cnt = q_q.cnt + CW'(push_i && !full_o) - CW'(pop_i && !empty_o);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
    end

    p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_o |-> !push_i);
    p_cnt_tracks_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(q_q.vld) == int'(q_q.cnt));
    p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_o |-> !pop_i);
endmodule

// File: rtl/iq_line_state.sv
module iq_line_state
    import iq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int LW = $clog2(NUM_LINES)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          inv_en_i,
    input  logic [LW-1:0] inv_line_i,
    input  logic          fill_en_i,
    input  logic [LW-1:0] fill_line_i,
    input  line_st_e      fill_state_i,
    input  logic [LW-1:0] rd_line_i,
    output line_st_e      rd_state_o
);
    line_st_e st_q [NUM_LINES];
    line_st_e st_d [NUM_LINES];

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            st_d[i] = st_q[i];
            if (inv_en_i && inv_line_i == LW'(i))   st_d[i] = LS_INV;
            if (fill_en_i && fill_line_i == LW'(i)) st_d[i] = fill_state_i;
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (!rst_ni) st_q[i] <= LS_INV;
            else         st_q[i] <= st_d[i];
        end
    end

    assign rd_state_o = st_q[rd_line_i];

    p_applied_line_invalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inv_en_i && !(fill_en_i && fill_line_i == inv_line_i))
            |=> st_q[$past(inv_line_i)] == LS_INV);
    p_no_fill_collision_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inv_en_i && fill_en_i) |-> (inv_line_i != fill_line_i));
endmodule

// File: rtl/inval_queue_early_ack.sv
module inval_queue_early_ack
    import iq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DEPTH     = 4,
    localparam int LW = $clog2(NUM_LINES),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          inv_valid_i,
    input  logic [LW-1:0] inv_line_i,
    output logic          inv_ack_o,
    input  logic          upd_free_i,
    output logic          apply_valid_o,
    output logic [LW-1:0] apply_line_o,
    input  logic          fill_req_i,
    input  logic [LW-1:0] fill_line_i,
    input  logic [1:0]    fill_state_i,
    output logic          fill_ready_o,
    input  logic          ld_req_i,
    input  logic [LW-1:0] ld_line_i,
    output logic          ld_ready_o,
    output logic [1:0]    ld_state_o,
    input  logic          rbar_i,
    output logic          rbar_stall_o
);
    typedef struct packed {
        logic [CW-1:0] bar_left;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [LW-1:0] head_line;
    logic [CW-1:0] q_count;
    logic          q_full, q_empty, fill_hit, do_pop, do_fill;
    logic [CW-1:0] bar_load;
    line_st_e      rd_state;

    assign rbar_stall_o = (ctl_q.bar_left != '0);
    assign inv_ack_o    = inv_valid_i && !q_full;
    assign do_pop       = !q_empty && (upd_free_i || rbar_stall_o || (fill_req_i && fill_hit));
    assign do_fill      = fill_req_i && !fill_hit;

    assign apply_valid_o = do_pop;
    assign apply_line_o  = head_line;
    assign fill_ready_o  = do_fill;
    assign ld_ready_o    = ld_req_i && !rbar_stall_o;
    assign ld_state_o    = rd_state;

    iq_fifo #(.DEPTH(DEPTH), .LW(LW)) u_fifo (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .push_i       (inv_ack_o),
        .push_line_i  (inv_line_i),
        .pop_i        (do_pop),
        .probe_line_i (fill_line_i),
        .head_line_o  (head_line),
        .count_o      (q_count),
        .full_o       (q_full),
        .empty_o      (q_empty),
        .probe_hit_o  (fill_hit)
    );

    iq_line_state #(.NUM_LINES(NUM_LINES)) u_state (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .inv_en_i     (do_pop),
        .inv_line_i   (head_line),
        .fill_en_i    (do_fill),
        .fill_line_i  (fill_line_i),
        .fill_state_i (line_st_e'(fill_state_i)),
        .rd_line_i    (ld_line_i),
        .rd_state_o   (rd_state)
    );

    always_comb begin
        ctl_d    = ctl_q;
        bar_load = rbar_i ? q_count : ctl_q.bar_left;
        ctl_d.bar_left = bar_load - CW'(do_pop && bar_load != '0);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    p_full_withholds_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_full |-> !inv_ack_o);
    p_stall_blocks_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rbar_stall_o |-> !ld_ready_o);
    p_stall_ends_on_apply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rbar_stall_o) |-> $past(apply_valid_o));
    p_stall_drains_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rbar_stall_o && !q_empty) |-> apply_valid_o);
    p_idle_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!upd_free_i && !rbar_stall_o && !fill_req_i) |-> !apply_valid_o);
endmodule

// File: tb/inval_queue_early_ack_tb.sv
module inval_queue_early_ack_tb;
    localparam int NL = 16;
    localparam int DP = 4;
    localparam int LW = 4;

    logic clk = 0;
    logic rst_n = 0;
    always #10 clk = ~clk;

    logic          inv_valid = 0, upd_free = 0, fill_req = 0, ld_req = 0, rbar = 0;
    logic [LW-1:0] inv_line = 0, fill_line = 0, ld_line = 0;
    logic [1:0]    fill_state = 0;
    logic          inv_ack, apply_valid, fill_ready, ld_ready, rbar_stall;
    logic [LW-1:0] apply_line;
    logic [1:0]    ld_state;

    inval_queue_early_ack #(.NUM_LINES(NL), .DEPTH(DP)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .inv_valid_i(inv_valid), .inv_line_i(inv_line), .inv_ack_o(inv_ack),
        .upd_free_i(upd_free), .apply_valid_o(apply_valid), .apply_line_o(apply_line),
        .fill_req_i(fill_req), .fill_line_i(fill_line), .fill_state_i(fill_state),
        .fill_ready_o(fill_ready), .ld_req_i(ld_req), .ld_line_i(ld_line),
        .ld_ready_o(ld_ready), .ld_state_o(ld_state), .rbar_i(rbar), .rbar_stall_o(rbar_stall)
    );

    int n_run = 0, n_fail = 0;
    logic [LW-1:0] mq [DP];
    int mcnt = 0, mbar = 0;
    logic [1:0] mst [NL];

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_hit(logic [LW-1:0] l);
        for (int i = 0; i < mcnt; i++) if (mq[i] == l) return 1;
        return 0;
    endfunction

    // one cycle: inputs already set at negedge
    task automatic tick();
        bit acc, app, fok, lok;
        int ld_exp, load;
        #1;
        acc = inv_valid && (mcnt < DP);
        fok = fill_req && !m_hit(fill_line);
        app = (mcnt > 0) && (upd_free || mbar != 0 || (fill_req && !fok));
        lok = ld_req && (mbar == 0);
        ld_exp = mst[ld_line];
        chk(mcnt < DP ? "R1 ack" : "R2 ack withheld", inv_ack, acc);
        chk("R3/R5 apply valid", apply_valid, app);
        if (app) chk("R3 apply order", apply_line, mq[0]);
        chk("R7 fill ready", fill_ready, fok);
        chk("R9 load ready", ld_ready, lok);
        if (lok) chk("R6/R4 load state", ld_state, ld_exp);
        chk("R8/R10 stall", rbar_stall, mbar != 0);
        @(posedge clk);
        if (app) mst[mq[0]] = 2'd0;
        if (fok) mst[fill_line] = fill_state;
        load = rbar ? mcnt : mbar;
        mbar = load - ((app && load != 0) ? 1 : 0);
        if (app) begin
            for (int i = 0; i < DP - 1; i++) mq[i] = mq[i+1];
            mcnt--;
        end
        if (acc) begin mq[mcnt] = inv_line; mcnt++; end
        @(negedge clk);
    endtask

    task automatic idle();
        inv_valid = 0; upd_free = 0; fill_req = 0; ld_req = 0; rbar = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1A2B;
        void'($urandom(seed));
        for (int i = 0; i < NL; i++) mst[i] = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        #1;
        chk("R11 stall", rbar_stall, 0);
        chk("R11 apply", apply_valid, 0);
        ld_req = 1; ld_line = 5; #1;
        chk("R11 line invalid", ld_state, 0);
        idle();
        // fill lines 0..5 Shared
        for (int i = 0; i < 6; i++) begin
            fill_req = 1; fill_line = LW'(i); fill_state = 2'd1; tick();
        end
        idle();
        // R10 barrier with empty queue
        rbar = 1; tick(); idle(); tick();
        // queue DP invalidates with update slot closed
        for (int i = 0; i < DP; i++) begin
            inv_valid = 1; inv_line = LW'(i); tick();
        end
        // R2 full: withheld twice
        inv_line = 4; tick(); tick();
        idle();
        // R6 stale Shared read
        ld_req = 1; ld_line = 1; tick();
        // R8 barrier drains, R9 loads blocked
        rbar = 1; tick(); rbar = 0;
        for (int i = 0; i < DP + 2; i++) tick();
        chk("R4 line now invalid", ld_state, 0);
        idle();
        // R7 fill collides with last queued entry
        for (int i = 0; i < 3; i++) begin inv_valid = 1; inv_line = LW'(8 + i); tick(); end
        idle();
        fill_req = 1; fill_line = 10; fill_state = 2'd2;
        for (int i = 0; i < 5; i++) tick();
        idle();
        ld_req = 1; ld_line = 10; tick(); idle();
        // random traffic
        for (int c = 0; c < 4000; c++) begin
            inv_valid  = ($urandom % 3) != 0;
            inv_line   = LW'($urandom % 8);
            upd_free   = ($urandom % 4) == 0;
            fill_req   = ($urandom % 4) == 0;
            fill_line  = LW'($urandom % 8);
            fill_state = 2'(1 + $urandom % 3);
            ld_req     = ($urandom % 2) == 0;
            ld_line    = LW'($urandom % 8);
            rbar       = ($urandom % 25) == 0;
            tick();
        end
        idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule